// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 64-bit register datapath and a byte-addressed memory port that is 64 bits wide. For a store it moves the register value onto the byte lanes selected by the low three address bits and drives one byte enable for each byte written. For a load it takes the addressed bytes out of the 64-bit memory word and returns them as a 64-bit result. The result is sign-extended or zero-extended, except for a single-precision float load, which places its word in the upper half of the result.

Access sizes of 1, 2, 4 and 8 bytes are supported. A run-time mode bit selects little-endian or big-endian byte order. An access whose address does not fit its size raises a fault and is suppressed; it is never split. Each request is taken in one cycle and all outputs are registered, so results appear one clock after the request.

Top module: `lsu_lane_align`

## Requirements
- R1: While reset is active and after it is released, `st_be`, `st_data`, `ld_data`, `ld_valid` and `fault` are all zero.
- R2: The `req_size` field gives the access length: 00 is 1 byte, 01 is 2, 10 is 4 and 11 is 8. A float load always uses length 4. A request is misaligned when `addr_lo` modulo the length is not zero. One cycle after a misaligned request, `fault` is 1, `st_be` is 0 and `ld_valid` is 0.
- R3: A misaligned load leaves `ld_data` at the value it held before the request.
- R4: One cycle after an aligned store, `st_be` bit i is 1 exactly for each memory lane i written, so the number of ones equals the access length.
- R5: Lane i of the memory word is bits [8i+7:8i]. In little-endian mode (`big_end`=0), byte k of the value (bits [8k+7:8k]) goes to lane `addr_lo`+k. Lanes that are not written carry zero in `st_data`.
- R6: In big-endian mode (`big_end`=1), a store places value byte k on lane `addr_lo`+length-1-k, so the lowest address holds the most significant byte.
- R7: Loads use the same lane mapping as stores in both modes, so the byte at the lowest address is the least significant byte in little-endian mode and the most significant byte in big-endian mode.
- R8: Loads of 1, 2 and 4 bytes fill the bits above the loaded value with the value's top bit when `req_signed`=1, and with zeros when `req_signed`=0.
- R9: An 8-byte load returns the whole 8-byte value whatever the value of `req_signed`.
- R10: A float load (`req_float`=1, load only) returns the 4 loaded bytes in `ld_data[63:32]` and zero in `ld_data[31:0]`.
- R11: In a cycle with no request, the next cycle has `st_be`=0, `ld_valid`=0 and `fault`=0, and `ld_data` is held.
- R12: `ld_valid` is 1 exactly in the cycle after an aligned load request, together with the new `ld_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | Access length code (00=1, 01=2, 10=4, 11=8 bytes) |
| req_signed | input | 1 | Sign-extend the narrow load result |
| req_float | input | 1 | Single-precision float load into the upper half |
| big_end | input | 1 | Byte order: 0 little-endian, 1 big-endian |
| addr_lo | input | 3 | Low three bits of the byte address |
| st_reg | input | 64 | Register value to store |
| mem_rdata | input | 64 | Memory word returned for a load |
| st_data | output | 64 | Store data placed on byte lanes |
| st_be | output | 8 | Store byte enables, one bit per lane |
| ld_data | output | 64 | Extended load result |
| ld_valid | output | 1 | Load result updated this cycle |
| fault | output | 1 | The previous request was misaligned |

## Verification
The hardest case to reach is a misaligned load that follows a successful load. Only then does the held `ld_data` show whether a fault result leaked through. The stimulus therefore runs a directed aligned load with a recognisable pattern, then a misaligned load of each size. In the random phase, address and size are drawn independently, so about half of the requests are misaligned and they are mixed freely with good loads. Big-endian float loads at address 4 get directed cases, because the upper-half placement and the reversed lane order combine there.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam int unsigned LANES  = 8;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = LANES * BYTE_W;
  localparam int unsigned AW     = $clog2(LANES);

  // number of bytes touched by a request
  function automatic logic [AW:0] access_len(input logic [1:0] sz, input logic is_flt);
    logic [AW:0] n;
    n = (AW+1)'(1) << sz;
    if (is_flt) n = (AW+1)'(4);
    return n;
  endfunction

  // lane that carries value byte k
  function automatic logic [AW-1:0] lane_for(input logic [AW-1:0] base, input logic [AW:0] len,
                                             input logic [AW:0] k, input logic big);
    logic [AW:0] off;
    off = big ? (len - (AW+1)'(1) - k) : k;
    return base + off[AW-1:0];
  endfunction
endpackage

// File: rtl/lane_misalign.sv
module lane_misalign
  import lane_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [AW:0]   len,
  output logic          bad
);
  logic [AW:0] mask;
  always_comb begin
    mask = len - (AW+1)'(1);
    bad  = |({1'b0, addr} & mask);
  end
endmodule

// File: rtl/lane_store_pack.sv
module lane_store_pack
  import lane_pkg::*;
(
  input  logic [AW-1:0]     addr,
  input  logic [AW:0]       len,
  input  logic              big,
  input  logic [WORD_W-1:0] src,
  output logic [WORD_W-1:0] lanes,
  output logic [LANES-1:0]  be
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [AW-1:0] off;
    logic [AW:0]   k;
    logic          hit;
    always_comb begin
      off = AW'(i) - addr;
      hit = ({1'b0, off} < len);
      k   = big ? (len - (AW+1)'(1) - {1'b0, off}) : {1'b0, off};
      be[i] = hit;
      lanes[i*BYTE_W +: BYTE_W] = hit ? src[k[AW-1:0]*BYTE_W +: BYTE_W] : '0;
    end
  end
endmodule

// File: rtl/lane_load_pick.sv
module lane_load_pick
  import lane_pkg::*;
(
  input  logic [AW-1:0]     addr,
  input  logic [AW:0]       len,
  input  logic              big,
  input  logic              sgn,
  input  logic              flt,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] raw;
  logic [LANES-1:0]  top_bits;
  logic              sign;

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    logic [AW-1:0] ln;
    logic          used;
    always_comb begin
      used = ((AW+1)'(k) < len);
      ln   = lane_for(addr, len, (AW+1)'(k), big);
      raw[k*BYTE_W +: BYTE_W] = used ? word[ln*BYTE_W +: BYTE_W] : '0;
      top_bits[k] = raw[k*BYTE_W + BYTE_W - 1];
    end
  end

  always_comb begin
    sign = top_bits[len - (AW+1)'(1)];
    if (flt) begin
      result = {raw[WORD_W/2-1:0], {(WORD_W/2){1'b0}}};
    end else begin
      result = raw;
      for (int b = 0; b < LANES; b++)
        if ((AW+1)'(b) >= len && sgn && sign) result[b*BYTE_W +: BYTE_W] = '1;
    end
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lane_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_store,
  input  logic [1:0]  req_size,
  input  logic        req_signed,
  input  logic        req_float,
  input  logic        big_end,
  input  logic [2:0]  addr_lo,
  input  logic [63:0] st_reg,
  input  logic [63:0] mem_rdata,
  output logic [63:0] st_data,
  output logic [7:0]  st_be,
  output logic [63:0] ld_data,
  output logic        ld_valid,
  output logic        fault
);
  logic [AW:0]       len;
  logic              misalign;
  logic              store_fire;
  logic              load_fire;
  logic              flt_load;
  logic [WORD_W-1:0] pk_data;
  logic [LANES-1:0]  pk_be;
  logic [WORD_W-1:0] ld_next;
  logic              last_flt;

  assign flt_load   = req_float & ~req_store;
  assign len        = access_len(req_size, flt_load);
  assign store_fire = req_valid & req_store & ~misalign;
  assign load_fire  = req_valid & ~req_store & ~misalign;

  lane_misalign u_mis (.addr(addr_lo), .len(len), .bad(misalign));

  lane_store_pack u_st (
    .addr(addr_lo), .len(len), .big(big_end), .src(st_reg),
    .lanes(pk_data), .be(pk_be)
  );

  lane_load_pick u_ld (
    .addr(addr_lo), .len(len), .big(big_end), .sgn(req_signed),
    .flt(flt_load), .word(mem_rdata), .result(ld_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_data  <= '0;
      st_be    <= '0;
      ld_data  <= '0;
      ld_valid <= 1'b0;
      fault    <= 1'b0;
      last_flt <= 1'b0;
    end else begin
      fault    <= req_valid & misalign;
      ld_valid <= load_fire;
      st_be    <= store_fire ? pk_be : '0;
      last_flt <= load_fire & flt_load;
      if (store_fire) st_data <= pk_data;
      if (load_fire)  ld_data <= ld_next;
    end
  end

  // R2
  fault_kills_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (st_be == '0) && !ld_valid);

  // R3
  fault_holds_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $stable(ld_data));

  // R4
  be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(st_be) == 0) || ($countones(st_be) == 1) || ($countones(st_be) == 2)
    || ($countones(st_be) == 4) || ($countones(st_be) == 8));

  // R10
  float_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && last_flt) |-> (ld_data[31:0] == 32'h0));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (st_be == '0) && !ld_valid && !fault && $stable(ld_data));

  // R12
  load_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> ld_valid);
endmodule

// File: tb/sim_lsu_lane_align.sv
module sim_lsu_lane_align;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0, req_float = 1'b0, big_end = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [2:0]  addr_lo = 3'd0;
  logic [63:0] st_reg = '0, mem_rdata = '0;
  logic [63:0] st_data, ld_data;
  logic [7:0]  st_be;
  logic        ld_valid, fault;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  logic [63:0] m_ld = '0, m_sd = '0;

  always #5 clk = ~clk;

  lsu_lane_align u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one request (or idle), then compare one cycle later
  task automatic op(input bit v, input bit st, input int n_code, input bit sg,
                    input bit fl, input bit be_big, input int a,
                    input logic [63:0] r, input logic [63:0] w);
    int n, lane;
    bit mis, isflt;
    logic [63:0] e_sd, e_ld;
    logic [7:0] e_be;
    string t;
    req_valid = v; req_store = st; req_size = 2'(n_code); req_signed = sg;
    req_float = fl; big_end = be_big; addr_lo = 3'(a); st_reg = r; mem_rdata = w;
    isflt = fl && !st;
    n = isflt ? 4 : (1 << n_code);
    mis = v && ((a % n) != 0);
    e_sd = 64'h0; e_be = 8'h0; e_ld = 64'h0;
    for (int k = 0; k < n; k++) begin
      lane = be_big ? (a + n - 1 - k) : (a + k);
      if (lane < 8) begin
        e_sd[lane*8 +: 8] = r[k*8 +: 8];
        e_be[lane] = 1'b1;
        e_ld[k*8 +: 8] = w[lane*8 +: 8];
      end
    end
    if (isflt) e_ld = {e_ld[31:0], 32'h0};
    else if (sg && n < 8 && e_ld[8*n-1]) e_ld = e_ld | ~((64'h1 << (8*n)) - 64'h1);
    @(negedge clk);
    if (!v) begin
      chk("R11 be", {56'h0, st_be}, 64'h0);
      chk("R11 fault", {63'h0, fault}, 64'h0);
      chk("R11 ldv", {63'h0, ld_valid}, 64'h0);
      chk("R11 ld", ld_data, m_ld);
    end else if (mis) begin
      chk("R2 fault", {63'h0, fault}, 64'h1);
      chk("R2 be", {56'h0, st_be}, 64'h0);
      chk("R2 ldv", {63'h0, ld_valid}, 64'h0);
      chk("R3 ld", ld_data, m_ld);
    end else if (st) begin
      m_sd = e_sd;
      chk("R4 be", {56'h0, st_be}, {56'h0, e_be});
      t = be_big ? "R6 data" : "R5 data";
      chk(t, st_data, m_sd);
      chk("R12 ldv", {63'h0, ld_valid}, 64'h0);
      chk("R2 nofault", {63'h0, fault}, 64'h0);
    end else begin
      m_ld = e_ld;
      if (isflt) t = "R10 ld";
      else if (n == 8) t = "R9 ld";
      else if (be_big) t = "R7 ld";
      else t = "R8 ld";
      chk(t, ld_data, m_ld);
      chk("R12 ldv", {63'h0, ld_valid}, 64'h1);
      chk("R4 be idle", {56'h0, st_be}, 64'h0);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sd", st_data, 64'h0);
    chk("R1 be", {56'h0, st_be}, 64'h0);
    chk("R1 ld", ld_data, 64'h0);
    chk("R1 flags", {62'h0, ld_valid, fault}, 64'h0);
    rst_n = 1'b1;
    op(0, 0, 0, 0, 0, 0, 0, '0, '0);
    // R5/R6 stores
    op(1, 1, 2, 0, 0, 0, 4, 64'h1122334455667788, '0);
    op(1, 1, 2, 0, 0, 1, 4, 64'h1122334455667788, '0);
    op(1, 1, 0, 0, 0, 0, 7, 64'h00000000000000ab, '0);
    op(1, 1, 1, 0, 0, 1, 2, 64'h000000000000cdef, '0);
    op(1, 1, 3, 0, 0, 1, 0, 64'h0102030405060708, '0);
    // R7/R8/R9 loads
    op(1, 0, 0, 1, 0, 0, 3, '0, 64'h00000000f0000000);
    op(1, 0, 0, 0, 0, 0, 3, '0, 64'h00000000f0000000);
    op(1, 0, 1, 1, 0, 1, 6, '0, 64'h8001000000000000);
    op(1, 0, 2, 1, 0, 0, 0, '0, 64'h00000000deadbeef);
    op(1, 0, 2, 0, 0, 1, 4, '0, 64'h89abcdef00000000);
    op(1, 0, 3, 1, 0, 0, 0, '0, 64'hfedcba9876543210);
    // R10 float loads
    op(1, 0, 0, 0, 1, 0, 4, '0, 64'h3f80000012345678);
    op(1, 0, 3, 1, 1, 1, 4, '0, 64'h0000803f00000000);
    // R2/R3 misaligned after a good load
    op(1, 0, 2, 0, 0, 0, 0, '0, 64'h00000000cafef00d);
    for (int s = 1; s < 4; s++) op(1, 0, s, 1, 0, 0, 1, '0, 64'hffffffffffffffff);
    op(1, 0, 0, 0, 1, 1, 2, '0, 64'h1);
    op(1, 1, 3, 0, 0, 0, 4, 64'h5555555555555555, '0);
    op(0, 0, 0, 0, 0, 0, 0, '0, '0);
    // random mix
    for (int i = 0; i < 600; i++)
      op(($urandom % 8) != 0, $urandom % 2, $urandom % 4, $urandom % 2, ($urandom % 4) == 0,
         $urandom % 2, $urandom % 8, {$urandom, $urandom}, {$urandom, $urandom});
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule